// File: doc/BRIEF.md
# Register File Soft-Error Guard

This block is a small register file that checks its own read data for soft errors. Every write stores the word and an 8-bit checksum of that word. A few recently used registers are also kept in a small fully associative cache. Each cache entry holds the register number, a valid flag and a copy of the value.

A read whose register sits in the cache is checked by comparing the array output with the cached copy. This costs no extra cycle. A read whose register is absent costs one stall cycle. During that cycle the checksum of the array word is recomputed and compared with the stored one. If that check passes, the register is placed in the cache, which is refilled in round-robin order.

A mismatch on either path gives a one-cycle error pulse together with the index of the failing register. A fault-injection port flips a single stored bit and leaves the cache and checksum untouched, so both detection paths can be exercised.

Top module: `rf_guard`

## Requirements
- R1: After reset every register reads as zero, the cache is empty, and stall_o and err_o are low.
- R2: rd_data_o shows the current contents of the register addressed by rd_addr_i in the same cycle, without waiting for a clock edge. A write with wr_en_i stores wr_data_i at the clock edge.
- R3: A read (rd_en_i high while stall_o is low) of a register absent from the cache raises stall_o for exactly the one cycle after the read edge. Read requests presented while stall_o is high are ignored.
- R4: When the stall-cycle checksum check passes, the register is placed in the cache, so the next read of it does not stall.
- R5: A read that hits the cache, when the array word differs from the cached copy, raises err_o in the cycle after the read edge, with err_addr_o equal to the register index.
- R6: A missed read whose array word fails the checksum check raises err_o in the cycle after the stall cycle, with err_addr_o equal to the register index.
- R7: A write to a cached register also updates the cached copy in the same edge, so later hits on it give no error.
- R8: The cache holds 4 entries and fills and evicts them in round-robin order. Cache hits do not advance the order. A register occupies at most one entry.
- R9: err_o is a single-cycle pulse per failed check. A register that fails the checksum check is not placed in the cache.
- R10: The checksum is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0, computed MSB first over the word. Rewriting a corrupted register stores a fresh checksum, which clears its error.
- R11: inj_en_i flips bit inj_bit_i of register inj_addr_i at the clock edge and changes neither the cache nor the checksum. A write to the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register index |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request, checked when stall_o is low |
| rd_addr_i | input | 4 | Read register index |
| rd_data_o | output | 32 | Read data, combinational from the array |
| stall_o | output | 1 | High during the checksum cycle that follows a cache miss |
| err_o | output | 1 | One-cycle pulse on a failed check |
| err_addr_o | output | 4 | Failing register index, valid while err_o is high |
| inj_en_i | input | 1 | Fault-injection enable |
| inj_addr_i | input | 4 | Register to corrupt |
| inj_bit_i | input | 5 | Bit to flip |

## Verification
Clean reads run through both paths first: a miss that stalls and then fills the cache, and a hit that does not stall. This separates cache membership from the data values. A single-bit flip on a cached register, and another on an uncached register, show that each path detects corruption. The error timing tells the two paths apart: one cycle after the read edge for a hit, one cycle later for a miss. A write to a cached register, a repeated read of a register that failed its check, and a sequence of five distinct misses followed by reads of the first and second victims confirm the cache update rule, the no-fill-on-failure rule and the round-robin order.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  localparam int unsigned CRC_W    = 8;
  localparam logic [7:0]  CRC_POLY = 8'h07;
endpackage

// File: rtl/rfg_crc8.sv
module rfg_crc8 #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]            data_i,
  output logic [rfg_pkg::CRC_W-1:0] crc_o
);
  import rfg_pkg::*;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/rfg_regfile.sv
module rfg_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned BW  = $clog2(DW)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      inj_en_i,
  input  logic [AW-1:0]             inj_addr_i,
  input  logic [BW-1:0]             inj_bit_i,
  input  logic [AW-1:0]             rd_addr_i,
  output logic [DW-1:0]             rd_data_o,
  input  logic [AW-1:0]             chk_addr_i,
  output logic [DW-1:0]             chk_data_o,
  output logic [rfg_pkg::CRC_W-1:0] chk_crc_o
);
  import rfg_pkg::*;

  logic [DW-1:0]    rf_q  [NREG];
  logic [CRC_W-1:0] crc_q [NREG];
  logic [CRC_W-1:0] wr_crc;

  rfg_crc8 #(.DW(DW)) u_wr_crc (.data_i(wr_data_i), .crc_o(wr_crc));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_hit, inj_hit;
    assign wr_hit  = wr_en_i && (wr_addr_i == AW'(g));
    assign inj_hit = inj_en_i && (inj_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rf_q[g]  <= '0;
        crc_q[g] <= '0;
      end else if (wr_hit) begin
        rf_q[g]  <= wr_data_i;
        crc_q[g] <= wr_crc;
      end else if (inj_hit) begin
        // corrupt the word only; checksum stays stale on purpose
        rf_q[g] <= rf_q[g] ^ (DW'(1) << inj_bit_i);
      end
    end
  end

  assign rd_data_o  = rf_q[rd_addr_i];
  assign chk_data_o = rf_q[chk_addr_i];
  assign chk_crc_o  = crc_q[chk_addr_i];
endmodule

// File: rtl/rfg_cache.sv
module rfg_cache #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned NWAY = 4,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned PW  = (NWAY > 1) ? $clog2(NWAY) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_val_o,
  input  logic          upd_en_i,
  input  logic [AW-1:0] upd_addr_i,
  input  logic [DW-1:0] upd_data_i,
  input  logic          alloc_en_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [DW-1:0] alloc_data_i
);
  logic [NWAY-1:0] valid_q;
  logic [AW-1:0]   idx_q [NWAY];
  logic [DW-1:0]   val_q [NWAY];
  logic [PW-1:0]   ptr_q;
  logic [NWAY-1:0] hit_vec;

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic upd_hit, alloc_sel;
    assign hit_vec[w] = valid_q[w] && (idx_q[w] == lk_addr_i);
    assign upd_hit    = upd_en_i && valid_q[w] && (idx_q[w] == upd_addr_i);
    assign alloc_sel  = alloc_en_i && (ptr_q == PW'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        idx_q[w]   <= '0;
        val_q[w]   <= '0;
      end else if (alloc_sel) begin
        valid_q[w] <= 1'b1;
        idx_q[w]   <= alloc_addr_i;
        val_q[w]   <= alloc_data_i;
      end else if (upd_hit) begin
        val_q[w] <= upd_data_i;
      end
    end
  end

  always_comb begin
    lk_val_o = '0;
    for (int w = 0; w < NWAY; w++)
      if (hit_vec[w]) lk_val_o = val_q[w];
  end
  assign lk_hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (alloc_en_i) ptr_q <= (ptr_q == PW'(NWAY - 1)) ? '0 : ptr_q + 1'b1;
  end

  AST_ONE_ENTRY_PER_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R8
  AST_FILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> valid_q[$past(ptr_q)]); // R4
endmodule

// File: rtl/rfg_ctrl.sv
module rfg_ctrl #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             rd_addr_i,
  input  logic [DW-1:0]             rd_data_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      lk_hit_i,
  input  logic [DW-1:0]             lk_val_i,
  output logic [AW-1:0]             chk_addr_o,
  input  logic [DW-1:0]             chk_data_i,
  input  logic [rfg_pkg::CRC_W-1:0] chk_crc_i,
  output logic                      alloc_en_o,
  output logic [DW-1:0]             alloc_data_o,
  output logic                      stall_o,
  output logic                      err_o,
  output logic [AW-1:0]             err_addr_o
);
  import rfg_pkg::*;

  logic             stall_q, err_q;
  logic [AW-1:0]    pend_q, err_addr_q;
  logic [CRC_W-1:0] chk_crc_calc;
  logic             rd_acc, hit_fail, chk_fail, err_d;

  rfg_crc8 #(.DW(DW)) u_chk_crc (.data_i(chk_data_i), .crc_o(chk_crc_calc));

  assign rd_acc   = rd_en_i && !stall_q;
  assign hit_fail = rd_acc && lk_hit_i && (lk_val_i != rd_data_i);
  assign chk_fail = stall_q && (chk_crc_calc != chk_crc_i);
  assign err_d    = hit_fail || chk_fail;

  assign chk_addr_o   = pend_q;
  assign alloc_en_o   = stall_q && !chk_fail;
  // a same-cycle write to the pending register must land in the fill
  assign alloc_data_o = (wr_en_i && wr_addr_i == pend_q) ? wr_data_i : chk_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q    <= 1'b0;
      pend_q     <= '0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      stall_q    <= rd_acc && !lk_hit_i;
      if (rd_acc) pend_q <= rd_addr_i;
      err_q      <= err_d;
      err_addr_q <= err_d ? (stall_q ? pend_q : rd_addr_i) : '0;
    end
  end

  assign stall_o    = stall_q;
  assign err_o      = err_q;
  assign err_addr_o = err_addr_q;

  AST_STALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |=> !stall_q); // R3
  AST_STALL_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_q) |-> $past(rd_en_i)); // R3
  AST_ERR_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(rd_en_i || stall_q)); // R9
  AST_NO_FILL_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && $past(stall_q)) |-> $past(!alloc_en_o)); // R9
endmodule

// File: rtl/rf_guard.sv
module rf_guard #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned NWAY = 4,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned BW  = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          stall_o,
  output logic          err_o,
  output logic [AW-1:0] err_addr_o,
  input  logic          inj_en_i,
  input  logic [AW-1:0] inj_addr_i,
  input  logic [BW-1:0] inj_bit_i
);
  import rfg_pkg::*;

  logic [AW-1:0]    chk_addr;
  logic [DW-1:0]    chk_data, lk_val, alloc_data;
  logic [CRC_W-1:0] chk_crc;
  logic             lk_hit, alloc_en;

  rfg_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .inj_en_i, .inj_addr_i, .inj_bit_i,
    .rd_addr_i, .rd_data_o,
    .chk_addr_i(chk_addr), .chk_data_o(chk_data), .chk_crc_o(chk_crc)
  );

  rfg_cache #(.NREG(NREG), .DW(DW), .NWAY(NWAY)) u_cache (
    .clk_i, .rst_ni,
    .lk_addr_i(rd_addr_i), .lk_hit_o(lk_hit), .lk_val_o(lk_val),
    .upd_en_i(wr_en_i), .upd_addr_i(wr_addr_i), .upd_data_i(wr_data_i),
    .alloc_en_i(alloc_en), .alloc_addr_i(chk_addr), .alloc_data_i(alloc_data)
  );

  rfg_ctrl #(.NREG(NREG), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .rd_en_i, .rd_addr_i, .rd_data_i(rd_data_o),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .lk_hit_i(lk_hit), .lk_val_i(lk_val),
    .chk_addr_o(chk_addr), .chk_data_i(chk_data), .chk_crc_i(chk_crc),
    .alloc_en_o(alloc_en), .alloc_data_o(alloc_data),
    .stall_o, .err_o, .err_addr_o
  );

  AST_ERR_NOT_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !stall_o); // R6
endmodule

// File: tb/tb_rf_guard.sv
module tb_rf_guard;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 19;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_INJ = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;   // write data, read expected data, or flip bit
    logic        e_stall;
    logic        e_err;
    logic [3:0]  req;
  } vec_t;

  // Cache starts empty; fills go to slots 0,1,2,3,0,... in order.
  localparam vec_t VECS [N_VEC] = '{
    '{OP_WR,  4'd1, 32'h1111_1111, 1'b0, 1'b0, 4'd2},  // R2
    '{OP_RD,  4'd1, 32'h1111_1111, 1'b1, 1'b0, 4'd3},  // R3 miss -> slot0
    '{OP_RD,  4'd1, 32'h1111_1111, 1'b0, 1'b0, 4'd4},  // R4 hit
    '{OP_INJ, 4'd1, 32'd0,         1'b0, 1'b0, 4'd11}, // R11
    '{OP_RD,  4'd1, 32'h1111_1110, 1'b0, 1'b1, 4'd5},  // R5 hit error
    '{OP_WR,  4'd1, 32'hA5A5_A5A5, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_RD,  4'd1, 32'hA5A5_A5A5, 1'b0, 1'b0, 4'd7},  // R7 hit, no error
    '{OP_INJ, 4'd2, 32'd31,        1'b0, 1'b0, 4'd11}, // R11
    '{OP_RD,  4'd2, 32'h8000_0000, 1'b1, 1'b1, 4'd6},  // R6 miss error
    '{OP_RD,  4'd2, 32'h8000_0000, 1'b1, 1'b1, 4'd9},  // R9 not filled
    '{OP_WR,  4'd2, 32'h0000_0002, 1'b0, 1'b0, 4'd10}, // R10
    '{OP_RD,  4'd2, 32'h0000_0002, 1'b1, 1'b0, 4'd10}, // R10 -> slot1
    '{OP_RD,  4'd3, 32'd0,         1'b1, 1'b0, 4'd8},  // R8 slot2
    '{OP_RD,  4'd4, 32'd0,         1'b1, 1'b0, 4'd8},  // R8 slot3
    '{OP_RD,  4'd5, 32'd0,         1'b1, 1'b0, 4'd8},  // R8 evicts r1
    '{OP_RD,  4'd2, 32'h0000_0002, 1'b0, 1'b0, 4'd8},  // R8 r2 kept
    '{OP_RD,  4'd1, 32'hA5A5_A5A5, 1'b1, 1'b0, 4'd8},  // R8 r1 -> slot1
    '{OP_RD,  4'd2, 32'h0000_0002, 1'b1, 1'b0, 4'd8},  // R8 r2 evicted
    '{OP_RD,  4'd3, 32'd0,         1'b1, 1'b0, 4'd8}   // R8 r3 evicted
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  inj_bit = '0;
  logic [31:0] rd_data;
  logic        stall, err;
  logic [3:0]  err_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_guard dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .stall_o(stall), .err_o(err), .err_addr_o(err_addr),
    .inj_en_i(inj_en), .inj_addr_i(inj_addr), .inj_bit_i(inj_bit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] ed,
                         input logic es, input logic ee, input int rq);
    string tag;
    tag = $sformatf("R%0d", rq);
    rd_en = 1'b1; rd_addr = a;
    #1 check({tag, " rd_data"}, rd_data, ed);          // R2
    next_cyc();
    rd_en = 1'b0;
    check({tag, " stall"}, {31'd0, stall}, {31'd0, es});
    if (es) begin
      check({tag, " no err during stall"}, {31'd0, err}, 32'd0);
      next_cyc();
      check({tag, " stall released"}, {31'd0, stall}, 32'd0);
    end
    check({tag, " err"}, {31'd0, err}, {31'd0, ee});
    if (ee) check({tag, " err_addr"}, {28'd0, err_addr}, {28'd0, a});
    next_cyc();
    check({tag, " R9 pulse end"}, {31'd0, err}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 stall", {31'd0, stall}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    next_cyc();
    rd_addr = 4'd9;
    #1 check("R1 reg zero", rd_data, 32'd0);

    for (int i = 0; i < N_VEC; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.op)
        OP_WR: begin
          wr_en = 1'b1; wr_addr = v.addr; wr_data = v.data;
          next_cyc();
          wr_en = 1'b0;
        end
        OP_INJ: begin
          inj_en = 1'b1; inj_addr = v.addr; inj_bit = v.data[4:0];
          next_cyc();
          inj_en = 1'b0;
        end
        default: do_read(v.addr, v.data, v.e_stall, v.e_err, int'(v.req));
      endcase
    end

    // R3: a read presented during the stall cycle is ignored
    rd_en = 1'b1; rd_addr = 4'd7;                 // miss
    next_cyc();
    rd_addr = 4'd8;                               // held during stall
    check("R3 stall on miss", {31'd0, stall}, 32'd1);
    next_cyc();
    rd_en = 1'b0;
    check("R3 ignored read no stall", {31'd0, stall}, 32'd0);
    next_cyc();
    // r8 was not taken in, so reading it now misses
    do_read(4'd8, 32'd0, 1'b1, 1'b0, 3);

    // R11: write wins over injection on the same register
    wr_en = 1'b1; wr_addr = 4'd10; wr_data = 32'h0F0F_0F0F;
    inj_en = 1'b1; inj_addr = 4'd10; inj_bit = 5'd3;
    next_cyc();
    wr_en = 1'b0; inj_en = 1'b0;
    do_read(4'd10, 32'h0F0F_0F0F, 1'b1, 1'b0, 11);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule